// File: doc/BRIEF.md
# Dual-Mode Per-CPU Timer Bank

This block holds one timer for each of N processors and a small system-side mode register that chooses, per processor, how that timer behaves. In limit mode a timer counts ticks up to a programmable limit, wraps to zero, latches a reached flag and raises the processor's interrupt. In user mode the same timer becomes a 64-bit counter that software can preload, start and stop. In this mode it never interrupts.

All counts advance in units of bit 9 (value 0x200) once per tick. A shared divider produces one tick every `TICK_DIV` clocks, 500 ns at the intended clock. Software reaches the timers and the mode register over one word-addressed bus. `sel_i` picks the space: values 0..N-1 are the CPU timers and value N is the system space. `idx_i` picks the word. Reads return data combinationally in the cycle of the access. Writes and read side effects take effect at the next clock edge.

Top module: `dmode_timer_bank`

## Requirements
- R1: After reset the mode register reads 0, every timer runs in limit mode with limit 0, status (index 3) reads 1, and all interrupts are low.
- R2: In limit mode with limit field L = bits 30:9 (L = 0 meaning 0x3FFFFF), the tick count runs 0..L-1 and then wraps to 0. On the wrap it sets the reached flag, which is bit 31 of an index 1 read, and raises the interrupt. Interrupts therefore recur every L ticks.
- R3: In limit mode, a write to index 0 loads the limit (bits 30:9), restarts the count at 0 and drops the interrupt. A read of index 0 returns the limit in bits 30:9 and clears both the reached flag and the interrupt.
- R4: A write to index 2 replaces the limit without restarting the count.
- R5: In limit mode, writes to index 1 and index 3 have no effect.
- R6: The mode register is word 4 of the system space (sel_i = N). Bit i selects user mode for timer i. Only the low N bits are kept and the other bits read 0. On a CPU timer, index 4 reads 0 and writes to it are ignored.
- R7: When a timer's mode bit changes, the timer restarts from count 0, running, with its reached flag clear. Entering user mode also drops its interrupt. The limit value is retained across mode changes.
- R8: In user mode, index 0 reads {reached, count[62:32]} and index 1 reads count[31:0]. Bits 8:0 read 0. The count rises by 0x200 per tick while running, with carry from the low word into the high word.
- R9: In user mode, a write to index 0 loads count[62:32] from bits 30:0, and a write to index 1 loads count[31:9] from bits 31:9. The other half is kept, and the reached flag and interrupt are cleared.
- R10: In user mode, a write to index 3 with bit 0 = 1 starts the counter and one with bit 0 = 0 stops it. Index 3 reads the running state in bit 0. A stopped counter holds its value, and that value stays readable and writable.
- R11: In user mode, a tick at count 0x7FFFFFFFFFFFFE00 wraps the count to 0 and sets the reached flag. The interrupt is never raised.
- R12: One tick occurs every TICK_DIV clocks, and the count advances by exactly one unit per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | $clog2(N_CPU+1) | Space select: CPU timer 0..N_CPU-1, system space N_CPU |
| idx_i | input | 3 | Word index within the selected space |
| rd_i | input | 1 | Read strobe (drives read side effects) |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the current sel_i/idx_i |
| irq_o | output | N_CPU | Per-CPU timer interrupt |

## Verification
The bench sweeps small limits and measures the interrupt period in clocks. A period off by one tick exposes an off-by-one wrap compare or a divider that counts TICK_DIV+1. It preloads a user counter to the last count before the maximum and to the lo-word boundary, which catches a missing carry, a wrap at the wrong width or an interrupt leaking out in user mode. It flips mode bits while a limit interrupt is pending and while a user counter is stopped. A design that fails to restart, leaves the counter stopped or keeps the interrupt would be reported there. Writes that must be ignored (index 1 and 3 in limit mode, index 4 on a CPU timer) are followed by reads that would show a loaded count, a stopped timer or a changed mode word.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int WORD_W   = 32;
  localparam int IDX_W    = 3;
  localparam int TICK_SH  = 9;                      // one count unit = bit 9
  localparam int CNT_W    = 63 - TICK_SH;           // user counter, tick units
  localparam int LO_W     = WORD_W - TICK_SH;       // tick bits in low word
  localparam int HI_W     = CNT_W - LO_W;           // tick bits in high word
  localparam int LIM_W    = 31 - TICK_SH;           // limit field, tick units

  localparam logic [IDX_W-1:0] IDX_LIM    = 3'd0;
  localparam logic [IDX_W-1:0] IDX_CNT    = 3'd1;
  localparam logic [IDX_W-1:0] IDX_LIM_NR = 3'd2;
  localparam logic [IDX_W-1:0] IDX_STAT   = 3'd3;
  localparam logic [IDX_W-1:0] IDX_MODE   = 3'd4;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int TICK_DIV = 62
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == LAST);
endmodule

// File: rtl/tmr_mode_reg.sv
module tmr_mode_reg #(
  parameter int N_CPU = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [N_CPU-1:0] wdata_i,
  output logic [N_CPU-1:0] mode_o,
  output logic [N_CPU-1:0] chg_o
);
  logic [N_CPU-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= '0;
    else if (wr_i) mode_q <= wdata_i;
  end

  // per-timer restart strobe, aligned with the register update
  assign chg_o  = wr_i ? (wdata_i ^ mode_q) : '0;
  assign mode_o = mode_q;
endmodule

// File: rtl/tmr_cpu.sv
module tmr_cpu
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              user_i,
  input  logic              restart_i,
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              run_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LIM_W-1:0] lim_q, lim_d, term;
  logic             rch_q, rch_d, irq_q, irq_d, run_q, run_d;
  logic             lim_wrap, usr_wrap, adv;

  assign term     = (lim_q == '0) ? '1 : lim_q;
  assign lim_wrap = (cnt_q[LIM_W-1:0] == term - 1'b1);
  assign usr_wrap = &cnt_q;
  assign adv      = tick_i && (!user_i || run_q);

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    rch_d = rch_q;
    irq_d = irq_q;
    run_d = run_q;
    if (adv) begin
      if (user_i) begin
        if (usr_wrap) begin
          cnt_d = '0;
          rch_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (lim_wrap) begin
          cnt_d = '0;
          rch_d = 1'b1;
          irq_d = 1'b1;
        end else begin
          cnt_d = CNT_W'(cnt_q[LIM_W-1:0] + 1'b1);
        end
      end
    end
    if (sel_i && wr_i) begin
      unique case (idx_i)
        IDX_LIM: begin
          if (user_i) begin
            cnt_d = {wdata_i[HI_W-1:0], cnt_q[LO_W-1:0]};
            rch_d = 1'b0;
          end else begin
            lim_d = wdata_i[30:TICK_SH];
            cnt_d = '0;
          end
          irq_d = 1'b0;
        end
        IDX_CNT: begin
          if (user_i) begin
            cnt_d = {cnt_q[CNT_W-1:LO_W], wdata_i[WORD_W-1:TICK_SH]};
            rch_d = 1'b0;
            irq_d = 1'b0;
          end
        end
        IDX_LIM_NR: lim_d = wdata_i[30:TICK_SH];
        IDX_STAT:   if (user_i) run_d = wdata_i[0];
        default: ;
      endcase
    end
    // limit read acknowledges the interrupt
    if (sel_i && rd_i && !user_i && idx_i == IDX_LIM) begin
      rch_d = 1'b0;
      irq_d = 1'b0;
    end
    if (restart_i) begin
      cnt_d = '0;
      run_d = 1'b1;
      rch_d = 1'b0;
      if (!user_i) irq_d = 1'b0;  // entering user mode
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
      rch_q <= 1'b0;
      irq_q <= 1'b0;
      run_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
      rch_q <= rch_d;
      irq_q <= irq_d;
      run_q <= run_d;
    end
  end

  always_comb begin
    unique case (idx_i)
      IDX_LIM:  rdata_o = user_i ? {rch_q, cnt_q[CNT_W-1:LO_W]}
                                 : {1'b0, lim_q, {TICK_SH{1'b0}}};
      IDX_CNT:  rdata_o = user_i ? {cnt_q[LO_W-1:0], {TICK_SH{1'b0}}}
                                 : {rch_q, cnt_q[LIM_W-1:0], {TICK_SH{1'b0}}};
      IDX_STAT: rdata_o = {{(WORD_W-1){1'b0}}, run_q};
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = irq_q;
  assign run_o = run_q;
endmodule

// File: rtl/dmode_timer_bank.sv
module dmode_timer_bank
  import tmr_pkg::*;
#(
  parameter int N_CPU    = 2,
  parameter int TICK_DIV = 62,
  localparam int SEL_W   = $clog2(N_CPU + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [N_CPU-1:0]  irq_o
);
  localparam logic [SEL_W-1:0] SYS_SEL = SEL_W'(N_CPU);

  logic              tick_w;
  logic [N_CPU-1:0]  mode_w, chg_w, run_w;
  logic [WORD_W-1:0] trd_w [N_CPU];
  logic              sys_sel, mode_wr;

  assign sys_sel = (sel_i == SYS_SEL);
  assign mode_wr = sys_sel && wr_i && (idx_i == IDX_MODE);

  tmr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick_w)
  );

  tmr_mode_reg #(.N_CPU(N_CPU)) u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (mode_wr),
    .wdata_i (wdata_i[N_CPU-1:0]),
    .mode_o  (mode_w),
    .chg_o   (chg_w)
  );

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    tmr_cpu u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_w),
      .user_i    (mode_w[i]),
      .restart_i (chg_w[i]),
      .sel_i     (sel_i == SEL_W'(i)),
      .rd_i      (rd_i),
      .wr_i      (wr_i),
      .idx_i     (idx_i),
      .wdata_i   (wdata_i),
      .rdata_o   (trd_w[i]),
      .irq_o     (irq_o[i]),
      .run_o     (run_w[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (sys_sel) begin
      if (idx_i == IDX_MODE) rdata_o = WORD_W'(mode_w);
    end else begin
      for (int i = 0; i < N_CPU; i++)
        if (sel_i == SEL_W'(i)) rdata_o = trd_w[i];
    end
  end
endmodule

// File: rtl/dmode_timer_bank_chk.sv
module dmode_timer_bank_chk #(
  parameter int N_CPU    = 2,
  parameter int TICK_DIV = 62,
  localparam int SEL_W   = $clog2(N_CPU + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [N_CPU-1:0] mode_i,
  input logic [N_CPU-1:0] run_i,
  input logic [N_CPU-1:0] irq_i,
  input logic [SEL_W-1:0] sel_i,
  input logic [2:0]       idx_i,
  input logic             rd_i,
  input logic [31:0]      rdata_i
);
  // R8: count words never expose bits below the tick unit
  a_r8_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i < SEL_W'(N_CPU) && idx_i == 3'd1) |-> rdata_i[8:0] == 9'd0);

  // R6: mode word only carries N bits
  a_r6_mode_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_W'(N_CPU) && idx_i == 3'd4) |-> (rdata_i >> N_CPU) == 32'd0);

  for (genvar i = 0; i < N_CPU; i++) begin : g_p
    // R11: user mode never interrupts
    a_r11_no_user_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_i[i] |=> !irq_i[i]);
    // R10: a limit-mode timer cannot be stopped
    a_r10_limit_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mode_i[i] |-> run_i[i]);
    // R3: limit read acknowledges the interrupt
    a_r3_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == SEL_W'(i) && rd_i && idx_i == 3'd0 && !mode_i[i]) |=> !irq_i[i]);
  end

  if (TICK_DIV > 1) begin : g_tk
    // R12: ticks are single-cycle pulses spaced apart
    a_r12_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i |=> !tick_i);
  end
endmodule

bind dmode_timer_bank dmode_timer_bank_chk #(.N_CPU(N_CPU), .TICK_DIV(TICK_DIV)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_w),
  .mode_i  (mode_w),
  .run_i   (run_w),
  .irq_i   (irq_o),
  .sel_i   (sel_i),
  .idx_i   (idx_i),
  .rd_i    (rd_i),
  .rdata_i (rdata_o)
);

// File: tb/sim_dmode_timer_bank.sv
`timescale 1ns/1ps
module sim_dmode_timer_bank;
  localparam int N   = 2;
  localparam int DIV = 4;
  localparam int SW  = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] sel = '0;
  logic [2:0]    idx = '0;
  logic          rd = 1'b0, wr = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dmode_timer_bank #(.N_CPU(N), .TICK_DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .idx_i(idx), .rd_i(rd),
    .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // each access occupies one cycle, called and returning at a negedge
  task automatic bus_wr(input int s, input int i, input logic [31:0] d);
    sel = SW'(s); idx = 3'(i); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input int s, input int i, output logic [31:0] d);
    sel = SW'(s); idx = 3'(i); rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wait_irq(input int c);
    int guard = 0;
    while (!irq[c] && guard < 20000) begin @(negedge clk); guard++; end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] v, v1, v2;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq == '0, "R1 irq low", 32'(irq), 0);
    bus_rd(N, 4, v);  chk(v == 0, "R1 mode zero", v, 0);
    bus_rd(0, 3, v);  chk(v == 1, "R1 running", v, 1);
    bus_rd(1, 3, v);  chk(v == 1, "R1 running t1", v, 1);
    bus_rd(0, 0, v);  chk(v == 0, "R1 limit zero", v, 0);

    // R12 free-run rate
    bus_rd(0, 1, v1);
    repeat (DIV * 10 - 1) @(negedge clk);
    bus_rd(0, 1, v2);
    chk(v2 - v1 == (10 << 9), "R12 rate", v2 - v1, 10 << 9);

    // R2/R3 limit sweep
    for (int l = 1; l <= 6; l++) begin
      bus_wr(0, 0, 32'(l) << 9);
      chk(irq[0] == 1'b0, "R3 write drops irq", 32'(irq[0]), 0);
      wait_irq(0);
      bus_rd(0, 0, v);
      chk(v == (32'(l) << 9), "R3 limit readback", v, 32'(l) << 9);
      n = 1;
      while (!irq[0] && n < 1000) begin @(negedge clk); n++; end
      chk(n == l * DIV, "R2 period", 32'(n), 32'(l * DIV));
      bus_rd(0, 1, v);
      chk(v[31] == 1'b1 && v[30:9] < 22'(l), "R2 reached flag", v, 32'h8000_0000);
      bus_rd(0, 0, v);
      chk(irq[0] == 1'b0, "R3 read clears irq", 32'(irq[0]), 0);
      bus_rd(0, 1, v);
      chk(v[31] == 1'b0, "R3 read clears reached", v, 0);
    end

    // R5 ignored writes in limit mode (limit 6)
    bus_wr(0, 1, 32'hFFFF_FE00);
    bus_rd(0, 1, v);
    chk(v[30:9] < 22'd6, "R5 idx1 write ignored", v, 0);
    bus_wr(0, 3, 32'h0);
    bus_rd(0, 3, v);
    chk(v == 1, "R5 idx3 write ignored", v, 1);

    // R4 limit change without restart
    bus_wr(1, 0, 32'd1000 << 9);
    repeat (DIV * 10 - 1) @(negedge clk);
    bus_wr(1, 2, 32'd2000 << 9);
    bus_rd(1, 1, v);
    chk(v[30:9] >= 22'd9 && v[30:9] <= 22'd11, "R4 no restart", v, 32'd10 << 9);
    bus_rd(1, 0, v);
    chk(v == (32'd2000 << 9), "R4 new limit", v, 32'd2000 << 9);

    // R6 mode register width and CPU index 4
    bus_wr(N, 4, 32'hFFFF_FFFF);
    bus_rd(N, 4, v);  chk(v == 32'h3, "R6 low bits only", v, 3);
    bus_wr(0, 4, 32'h0);
    bus_rd(N, 4, v);  chk(v == 32'h3, "R6 cpu idx4 write ignored", v, 3);
    bus_rd(0, 4, v);  chk(v == 0, "R6 cpu idx4 reads zero", v, 0);
    bus_wr(N, 4, 32'h0);

    // R7 entering user mode with a pending interrupt
    bus_wr(0, 0, 32'd1 << 9);
    wait_irq(0);
    chk(irq[0] == 1'b1, "R2 irq pending", 32'(irq[0]), 1);
    bus_wr(N, 4, 32'h1);
    chk(irq[0] == 1'b0, "R7 enter user drops irq", 32'(irq[0]), 0);
    bus_rd(0, 0, v);  chk(v == 0, "R7 hi restarted", v, 0);
    bus_rd(0, 1, v);  chk(v <= 32'h400, "R7 lo restarted", v, 32'h200);
    bus_rd(0, 3, v);  chk(v == 1, "R7 running", v, 1);

    // R10 stop holds value
    bus_wr(0, 3, 32'h0);
    bus_rd(0, 3, v);  chk(v == 0, "R10 stopped", v, 0);
    bus_rd(0, 1, v1);
    repeat (20) @(negedge clk);
    bus_rd(0, 1, v2); chk(v2 == v1, "R10 holds", v2, v1);

    // R9 preload halves while stopped
    bus_wr(0, 1, 32'h1234_5600);
    bus_rd(0, 1, v);  chk(v == 32'h1234_5600, "R9 lo load", v, 32'h1234_5600);
    bus_wr(0, 0, 32'h00AB_CDEF);
    bus_rd(0, 0, v);  chk(v == 32'h00AB_CDEF, "R9 hi load", v, 32'h00AB_CDEF);
    bus_rd(0, 1, v);  chk(v == 32'h1234_5600, "R9 lo kept", v, 32'h1234_5600);

    // R8 rate after start
    bus_wr(0, 3, 32'h1);
    bus_rd(0, 1, v1);
    repeat (DIV * 7 - 1) @(negedge clk);
    bus_rd(0, 1, v2);
    chk(v2 - v1 == (7 << 9), "R8 user rate", v2 - v1, 7 << 9);

    // R8 carry into high word
    bus_wr(0, 3, 32'h0);
    bus_wr(0, 1, 32'hFFFF_FE00);
    bus_wr(0, 0, 32'h0);
    bus_wr(0, 3, 32'h1);
    repeat (2 * DIV) @(negedge clk);
    bus_rd(0, 0, v);  chk(v == 32'h1, "R8 carry", v, 1);

    // R11 wrap at maximum without interrupt
    bus_wr(0, 3, 32'h0);
    bus_wr(0, 0, 32'h7FFF_FFFF);
    bus_wr(0, 1, 32'hFFFF_FE00);
    bus_rd(0, 0, v);  chk(v == 32'h7FFF_FFFF, "R9 max hi", v, 32'h7FFF_FFFF);
    bus_wr(0, 3, 32'h1);
    for (int k = 0; k < 2 * DIV; k++) begin
      @(negedge clk);
      if (irq[0]) chk(1'b0, "R11 no irq", 32'(irq[0]), 0);
    end
    chk(irq[0] == 1'b0, "R11 irq low", 32'(irq[0]), 0);
    bus_rd(0, 0, v);  chk(v == 32'h8000_0000, "R11 wrapped reached", v, 32'h8000_0000);
    bus_wr(0, 1, 32'h0);
    bus_rd(0, 0, v);  chk(v[31] == 1'b0, "R9 write clears reached", v, 0);

    // R7 leaving user mode while stopped
    bus_wr(0, 3, 32'h0);
    bus_wr(N, 4, 32'h0);
    bus_rd(0, 3, v);  chk(v == 1, "R7 leave restarts running", v, 1);
    bus_rd(0, 0, v);  chk(v == (32'd1 << 9), "R7 limit retained", v, 32'd1 << 9);
    wait_irq(0);
    chk(irq[0] == 1'b1, "R7 limit mode active", 32'(irq[0]), 1);
    bus_rd(0, 0, v);

    // timer 1 unaffected by timer 0 mode traffic
    bus_wr(1, 0, 32'd3 << 9);
    wait_irq(1);
    bus_rd(1, 0, v);
    n = 1;
    while (!irq[1] && n < 1000) begin @(negedge clk); n++; end
    chk(n == 3 * DIV, "R2 period t1", 32'(n), 32'(3 * DIV));

    finish_up();
  end
endmodule